// File: doc/BRIEF.md
# Three-Bank Interrupt Aggregator with Dual Masking

This block collects 24 single-cycle event pulses from the function blocks of a power-management chip. It latches them into three 8-bit status banks and drives one active-high interrupt request toward a host. The host reaches the block through a simple byte-wide register port: a write strobe with address and data, and a read path that is purely combinational from the address. That port is normally bridged from a serial bus that lies outside this block.

Each bank has two masks. The capture mask decides whether an incoming event is recorded in status at all. The line mask decides whether a recorded bit contributes to the interrupt output. A mask bit of 1 blocks its source. A bit of 0 lets it through.

The three status registers sit at consecutive addresses, so a three-byte burst read returns bank A, then B, then C. The same holds for each group of three masks. A host services an interrupt by reading the three status bytes and then writing one byte to any status address. That single write wipes all 24 status bits.

Top module: `pmic_irq_agg`

## Requirements
- R1: After reset every line-mask and capture-mask register reads 0xFF, every status register reads 0x00, and irq_o is 0.
- R2: Source n lands in bit (n mod 8) of bank n/8, where bank A holds sources 0-7, B holds 8-15 and C holds 16-23. An event is latched at the clock edge where it is sampled only when its capture-mask bit is 0. With the capture-mask bit at 1 the event leaves status unchanged.
- R3: irq_o is 1 exactly when some status bit is 1 and its line-mask bit is 0.
- R4: A write of any data value to status address 0x0, 0x1 or 0x2 clears all three status registers at that edge.
- R5: An enabled event that arrives in the same cycle as a status-clear write is kept in status after the clear.
- R6: Sources 12 and 23 are reserved. Their status bits never set and always read 0, whatever the masks.
- R7: Register map on a 4-bit address. Status A/B/C sit at 0x0/0x1/0x2, line masks A/B/C at 0x4/0x5/0x6, and capture masks A/B/C at 0x8/0x9/0xA. Mask registers take the written byte at the write edge and read it back.
- R8: Reads from any other address return 0x00, and writes to them change no register.
- R9: Reading a status register has no side effect. Repeated reads return the same value.
- R10: A line-mask write leaves status unchanged. irq_o reflects the new mask from the clock edge that performs the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 24 | Event pulses, one bit per source |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address for reads and writes |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
The assertions check four things on every cycle:
- the reserved status bits stay zero;
- after a clear, status holds only the events that arrived alongside it;
- status holds still when there is neither an event nor a clear;
- irq_o stays low whenever all line masks are set.

Only the bench scenarios can show the remaining behaviour: the address map, the read-back of masks, routing of each source to its bank bit, clearing through each of the three status addresses, and unused addresses being inert. The same goes for the ordering around the clear-versus-event collision and the cycle in which irq_o follows a line-mask change.

// File: rtl/pmic_irq_pkg.sv
package pmic_irq_pkg;

    localparam int BANK_W    = 8;
    localparam int NUM_BANKS = 3;
    localparam int SRC_N     = BANK_W * NUM_BANKS;
    localparam int ADDR_W    = 4;

    localparam logic [ADDR_W-1:0] STS_BASE  = 4'h0;
    localparam logic [ADDR_W-1:0] LMSK_BASE = 4'h4;
    localparam logic [ADDR_W-1:0] CMSK_BASE = 4'h8;

    // sources that can never latch
    localparam logic [SRC_N-1:0] RSV_SRC = 24'h80_1000;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_STS  = 2'd1,
        RG_LMSK = 2'd2,
        RG_CMSK = 2'd3
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e   kind;
        logic [1:0]  bank;
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        s.kind = RG_NONE;
        s.bank = 2'd0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (a == STS_BASE + ADDR_W'(b)) begin
                s.kind = RG_STS;  s.bank = 2'(b);
            end
            if (a == LMSK_BASE + ADDR_W'(b)) begin
                s.kind = RG_LMSK; s.bank = 2'(b);
            end
            if (a == CMSK_BASE + ADDR_W'(b)) begin
                s.kind = RG_CMSK; s.bank = 2'(b);
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/pmic_irq_decode.sv
module pmic_irq_decode
    import pmic_irq_pkg::*;
#(
    parameter int NB = NUM_BANKS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_t          sel_o,
    output logic              clear_all_o,
    output logic [NB-1:0]     lmsk_we_o,
    output logic [NB-1:0]     cmsk_we_o
);

    always_comb begin
        sel_o       = decode_addr(addr_i);
        clear_all_o = wr_en_i && (sel_o.kind == RG_STS);
        lmsk_we_o   = '0;
        cmsk_we_o   = '0;
        for (int b = 0; b < NB; b++) begin
            if (wr_en_i && sel_o.bank == 2'(b)) begin
                lmsk_we_o[b] = (sel_o.kind == RG_LMSK);
                cmsk_we_o[b] = (sel_o.kind == RG_CMSK);
            end
        end
    end

    // R7 / R8: at most one mask register written per cycle
    assert_one_mask_we_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lmsk_we_o, cmsk_we_o}));

endmodule

// File: rtl/pmic_irq_bank.sv
module pmic_irq_bank
    import pmic_irq_pkg::*;
#(
    parameter int          W   = BANK_W,
    parameter logic [W-1:0] RSV = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt_i,
    input  logic         clear_i,
    input  logic         lmsk_we_i,
    input  logic         cmsk_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] status_o,
    output logic [W-1:0] lmsk_o,
    output logic [W-1:0] cmsk_o,
    output logic         irq_o
);

    logic [W-1:0] status_q, lmsk_q, cmsk_q;
    logic [W-1:0] accept;

    assign accept = evt_i & ~cmsk_q & ~RSV;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            lmsk_q   <= '1;
            cmsk_q   <= '1;
        end else begin
            // new events are OR-ed after the clear so they survive it
            status_q <= (clear_i ? '0 : status_q) | accept;
            if (lmsk_we_i) lmsk_q <= wdata_i;
            if (cmsk_we_i) cmsk_q <= wdata_i;
        end
    end

    assign status_o = status_q;
    assign lmsk_o   = lmsk_q;
    assign cmsk_o   = cmsk_q;
    assign irq_o    = |(status_q & ~lmsk_q);

    assert_rsv_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (status_q & RSV) == '0);

    assert_clear_keeps_new_R5: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> status_q == $past(evt_i & ~cmsk_q & ~RSV));

    assert_clear_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (clear_i && evt_i == '0) |=> status_q == '0);

    assert_status_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!clear_i && evt_i == '0) |=> $stable(status_q));

endmodule

// File: rtl/pmic_irq_rdmux.sv
module pmic_irq_rdmux
    import pmic_irq_pkg::*;
#(
    parameter int NB = NUM_BANKS,
    parameter int W  = BANK_W
) (
    input  reg_sel_t        sel_i,
    input  logic [NB*W-1:0] status_i,
    input  logic [NB*W-1:0] lmsk_i,
    input  logic [NB*W-1:0] cmsk_i,
    output logic [W-1:0]    rdata_o
);

    always_comb begin
        rdata_o = '0;
        for (int b = 0; b < NB; b++) begin
            if (sel_i.bank == 2'(b)) begin
                unique case (sel_i.kind)
                    RG_STS:  rdata_o = status_i[b*W +: W];
                    RG_LMSK: rdata_o = lmsk_i[b*W +: W];
                    RG_CMSK: rdata_o = cmsk_i[b*W +: W];
                    default: rdata_o = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/pmic_irq_agg.sv
module pmic_irq_agg
    import pmic_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_N-1:0]  evt_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BANK_W-1:0] wdata_i,
    output logic [BANK_W-1:0] rdata_o,
    output logic              irq_o
);

    localparam int NB = NUM_BANKS;
    localparam int W  = BANK_W;

    reg_sel_t          sel;
    logic              clear_all;
    logic [NB-1:0]     lmsk_we, cmsk_we, bank_irq;
    logic [NB*W-1:0]   status_all, lmsk_all, cmsk_all;

    pmic_irq_decode #(.NB(NB)) u_dec (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (wr_en_i),
        .addr_i     (addr_i),
        .sel_o      (sel),
        .clear_all_o(clear_all),
        .lmsk_we_o  (lmsk_we),
        .cmsk_we_o  (cmsk_we)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        pmic_irq_bank #(
            .W  (W),
            .RSV(RSV_SRC[b*W +: W])
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .evt_i    (evt_i[b*W +: W]),
            .clear_i  (clear_all),
            .lmsk_we_i(lmsk_we[b]),
            .cmsk_we_i(cmsk_we[b]),
            .wdata_i  (wdata_i),
            .status_o (status_all[b*W +: W]),
            .lmsk_o   (lmsk_all[b*W +: W]),
            .cmsk_o   (cmsk_all[b*W +: W]),
            .irq_o    (bank_irq[b])
        );
    end

    pmic_irq_rdmux #(.NB(NB), .W(W)) u_rd (
        .sel_i   (sel),
        .status_i(status_all),
        .lmsk_i  (lmsk_all),
        .cmsk_i  (cmsk_all),
        .rdata_o (rdata_o)
    );

    assign irq_o = |bank_irq;

    assert_irq_masked_R3: assert property (@(posedge clk) disable iff (rst)
        (&lmsk_all) |-> !irq_o);

    assert_irq_needs_status_R3: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (status_all != '0));

endmodule

// File: tb/pmic_irq_agg_test.sv
module pmic_irq_agg_test;
    import pmic_irq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 40;

    // op: 0 write, 1 event pulse, 2 read-compare, 3 irq-compare (data[0])
    localparam logic [37:0] VEC [NVEC] = '{
        {2'd0, 4'h8, 8'h00, 24'h000000}, // R7 capture A open
        {2'd1, 4'h0, 8'h00, 24'h000005}, // R2 sources 0,2
        {2'd2, 4'h0, 8'h05, 24'h000000}, // R2
        {2'd3, 4'h0, 8'h00, 24'h000000}, // R3 line masks all set
        {2'd0, 4'h4, 8'hFE, 24'h000000}, // R10
        {2'd3, 4'h0, 8'h01, 24'h000000}, // R10 irq same edge
        {2'd2, 4'h4, 8'hFE, 24'h000000}, // R7 readback
        {2'd0, 4'h4, 8'hFB, 24'h000000},
        {2'd3, 4'h0, 8'h01, 24'h000000}, // R3 via bit2
        {2'd0, 4'h4, 8'hFF, 24'h000000},
        {2'd3, 4'h0, 8'h00, 24'h000000}, // R3
        {2'd2, 4'h0, 8'h05, 24'h000000}, // R10 status untouched
        {2'd1, 4'h0, 8'h00, 24'h000100}, // R2 masked source 8
        {2'd2, 4'h1, 8'h00, 24'h000000}, // R2
        {2'd0, 4'h9, 8'h00, 24'h000000},
        {2'd1, 4'h0, 8'h00, 24'h001100}, // sources 8, 12
        {2'd2, 4'h1, 8'h01, 24'h000000}, // R6 bit 12 stays 0
        {2'd0, 4'hA, 8'h00, 24'h000000},
        {2'd1, 4'h0, 8'h00, 24'h810000}, // sources 16, 23
        {2'd2, 4'h2, 8'h01, 24'h000000}, // R6 bit 23 stays 0
        {2'd2, 4'hA, 8'h00, 24'h000000}, // R7
        {2'd0, 4'h2, 8'h5A, 24'h000000}, // R4 clear via C
        {2'd2, 4'h0, 8'h00, 24'h000000}, // R4
        {2'd2, 4'h1, 8'h00, 24'h000000}, // R4
        {2'd2, 4'h2, 8'h00, 24'h000000}, // R4
        {2'd0, 4'h3, 8'h77, 24'h000000}, // R8 unused write
        {2'd2, 4'h3, 8'h00, 24'h000000}, // R8
        {2'd0, 4'h7, 8'h00, 24'h000000}, // R8 unused write
        {2'd2, 4'h7, 8'h00, 24'h000000}, // R8
        {2'd2, 4'h4, 8'hFF, 24'h000000}, // R8 line A untouched
        {2'd2, 4'h8, 8'h00, 24'h000000}, // R8 cap A untouched
        {2'd2, 4'hF, 8'h00, 24'h000000}, // R8
        {2'd1, 4'h0, 8'h00, 24'h000201}, // sources 0, 9
        {2'd2, 4'h0, 8'h01, 24'h000000}, // R9
        {2'd2, 4'h0, 8'h01, 24'h000000}, // R9 repeat
        {2'd2, 4'h1, 8'h02, 24'h000000}, // R9
        {2'd2, 4'h0, 8'h01, 24'h000000}, // R9 repeat
        {2'd0, 4'h1, 8'hFF, 24'h000000}, // R4 clear via B
        {2'd2, 4'h0, 8'h00, 24'h000000}, // R4
        {2'd2, 4'h1, 8'h00, 24'h000000}  // R4
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [SRC_N-1:0]  evt = '0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [BANK_W-1:0] wdata = '0;
    logic [BANK_W-1:0] rdata;
    logic              irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmic_irq_agg uut (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt),
        .wr_en_i(wr_en),
        .addr_i (addr),
        .wdata_i(wdata),
        .rdata_o(rdata),
        .irq_o  (irq)
    );

    task automatic do_write(input logic [3:0] a, input logic [7:0] d, input logic [23:0] e);
        addr = a; wdata = d; wr_en = 1'b1; evt = e;
        @(negedge clk);
        wr_en = 1'b0; evt = '0;
    endtask

    task automatic do_event(input logic [23:0] e);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic chk_read(input logic [3:0] a, input logic [7:0] exp, input string req);
        addr = a;
        #1;
        n_checks++;
        if (rdata !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, rdata, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string req);
        #1;
        n_checks++;
        if (irq !== exp) begin
            n_fail++;
            $display("FAIL %s irq actual=%b expected=%b", req, irq, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int b = 0; b < 3; b++) begin
            chk_read(4'(b), 8'h00, "R1 status");
            chk_read(4'(4 + b), 8'hFF, "R1 line mask");
            chk_read(4'(8 + b), 8'hFF, "R1 capture mask");
        end
        chk_irq(1'b0, "R1 irq");

        // Host initialisation: mask everything, then clear
        for (int b = 0; b < 3; b++) begin
            do_write(4'(4 + b), 8'hFF, '0);
            do_write(4'(8 + b), 8'hFF, '0);
        end
        do_write(4'h0, 8'h00, '0);
        chk_read(4'h0, 8'h00, "R4 init clear");

        for (int i = 0; i < NVEC; i++) begin
            logic [1:0]  op;
            logic [3:0]  a;
            logic [7:0]  d;
            logic [23:0] e;
            {op, a, d, e} = VEC[i];
            case (op)
                2'd0: do_write(a, d, e);
                2'd1: do_event(e);
                2'd2: chk_read(a, d, $sformatf("R7 vec%0d", i));
                default: chk_irq(d[0], $sformatf("R3 vec%0d", i));
            endcase
        end

        // R5 collision: clear write and enabled event in one cycle
        do_event(24'h000001);
        chk_read(4'h0, 8'h01, "R5 pre");
        do_write(4'h0, 8'hAB, 24'h000002);
        chk_read(4'h0, 8'h02, "R5 event survives clear");

        // R3 irq from bank C with line mask C open
        do_write(4'h6, 8'hFE, '0);
        chk_irq(1'b0, "R3 no status in C");
        do_event(24'h010000);
        chk_irq(1'b1, "R3 bank C");
        do_write(4'h2, 8'h00, '0);
        chk_irq(1'b0, "R4 irq drops after clear");

        finish_run();
    end

endmodule